// File: doc/BRIEF.md
# Sleep-Aware Watchdog Timer

This block counts ticks from its own tick-enable input. It does not use the processor clock gating, so counting goes on while the core is halted in its low-power state. Software must restart the count with a clear strobe before the count reaches a fixed interval. If the interval runs out while the core is running, the block issues a one-cycle device reset request. If the core is asleep when the interval runs out, the block issues a one-cycle wake request instead, so that execution can resume.

The watchdog is armed when the static configuration enable or the software enable is set. While neither is set, the count is held at zero. A sticky status flag records that a timeout took place and stays set until the next clear strobe. The interval is the parameter `TIMEOUT`, given in ticks.

Top module: `wdt_sleep_aware`

## Requirements
- R1: The watchdog is armed when `cfg_en` is 1, when `sw_en` is 1, or when both are 1. Either input alone is enough to let the count advance.
- R2: While armed, the count advances by exactly one on each clock cycle in which `tick` is 1. Cycles with `tick` at 0 leave it unchanged. The value of `asleep` does not stop the count.
- R3: On the `TIMEOUT`-th tick after the count was last restarted, with `asleep` at 0 and no clear strobe in that cycle, `rst_pulse` is 1 for exactly one clock cycle. That cycle directly follows the clock edge at which the tick was taken.
- R4: In the same situation with `asleep` at 1, `wake_pulse` is 1 for exactly one cycle and `rst_pulse` stays 0.
- R5: After either pulse the count restarts from zero, so the next timeout takes another full `TIMEOUT` ticks.
- R6: A clear strobe (`kick` at 1) restarts the count from zero. If a clear strobe and the timeout tick fall in the same cycle, the clear wins and neither pulse is produced.
- R7: While the watchdog is disarmed, the count is held at zero and neither pulse is produced, whatever ticks arrive. After it is armed again, a full `TIMEOUT` ticks are needed before a timeout.
- R8: `timed_out` goes to 1 together with either pulse. A clear strobe returns it to 0 in the following cycle. In all other cases it holds its value.
- R9: While `rst_n` is low and right after it is released, `rst_pulse`, `wake_pulse` and `timed_out` are all 0.
- R10: `rst_pulse` and `wake_pulse` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (always running) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Enable fixed at configuration time |
| sw_en | input | 1 | Enable controlled by software |
| kick | input | 1 | Clear strobe; restarts the count |
| asleep | input | 1 | 1 while the core is halted in sleep |
| tick | input | 1 | One-cycle advance enable from the timebase |
| rst_pulse | output | 1 | One-cycle device reset request |
| wake_pulse | output | 1 | One-cycle wake-up request |
| timed_out | output | 1 | Sticky flag: a timeout has occurred since the last clear |

## Verification
The hardest case to reach is the one where the clear strobe lands in exactly the same cycle as the tick that would complete the interval. The bench counts ticks one at a time from a known restart point. It then raises `kick` and `tick` together on the `TIMEOUT`-th tick. It confirms that no pulse appears and that a further full interval is needed. The bench also spreads ticks out with idle cycles while the core is asleep, so that the timeout can only be reached by ticks and not by elapsed clock cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    WDT_EV_NONE  = 2'd0,
    WDT_EV_RESET = 2'd1,
    WDT_EV_WAKE  = 2'd2
  } wdt_event_e;

  // True when the count has reached the last value before the interval closes.
  function automatic logic at_last_step(input int unsigned cnt, input int unsigned limit);
    return cnt == (limit - 1);
  endfunction

  // Chooses what a timeout turns into, depending on the sleep state.
  function automatic wdt_event_e classify(input logic fire, input logic sleeping);
    if (!fire)    return WDT_EV_NONE;
    if (sleeping) return WDT_EV_WAKE;
    return WDT_EV_RESET;
  endfunction

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned TIMEOUT = 16,
  localparam int unsigned CNT_W  = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             kick,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  import wdt_pkg::*;

  generate
    if (TIMEOUT < 2) begin : g_bad_timeout
      $error("wdt_counter: TIMEOUT must be at least 2");
    end
  endgenerate

  logic [CNT_W-1:0] count_q;
  logic             last_step;

  assign last_step = at_last_step(32'(count_q), TIMEOUT);
  // Clear strobe outranks the timeout.
  assign expire    = armed && tick && last_step && !kick;
  assign count     = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (!armed || kick) begin
      count_q <= '0;
    end else if (tick) begin
      if (last_step) count_q <= '0;
      else           count_q <= count_q + 1'b1;
    end
  end

  a_r2_holds_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !tick && !kick) |=> $stable(count_q));

  a_r2_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && tick && !kick && !last_step) |=> (count_q == $past(count_q) + 1'b1));

  a_r5_restart_after_expire: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count_q == '0));

  a_r6_kick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (count_q == '0));

  a_r7_held_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (count_q == '0));

  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count_q) < TIMEOUT);

endmodule

// File: rtl/wdt_event.sv
module wdt_event (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic asleep,
  input  logic kick,
  output logic rst_pulse,
  output logic wake_pulse,
  output logic timed_out
);
  import wdt_pkg::*;

  wdt_event_e ev;
  logic rst_q, wake_q, flag_q;

  assign ev = classify(expire, asleep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= 1'b0;
      wake_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      rst_q  <= (ev == WDT_EV_RESET);
      wake_q <= (ev == WDT_EV_WAKE);
      if (kick)        flag_q <= 1'b0;
      else if (expire) flag_q <= 1'b1;
    end
  end

  assign rst_pulse  = rst_q;
  assign wake_pulse = wake_q;
  assign timed_out  = flag_q;

  a_r3_reset_when_awake: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !asleep) |=> (rst_pulse && !wake_pulse));

  a_r4_wake_when_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && asleep) |=> (wake_pulse && !rst_pulse));

  a_r3_reset_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);

  a_r4_wake_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  a_r8_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pulse || wake_pulse) |-> timed_out);

  a_r8_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !timed_out);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_pulse, wake_pulse}));

endmodule

// File: rtl/wdt_sleep_aware.sv
module wdt_sleep_aware #(
  parameter int unsigned TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_en,
  input  logic sw_en,
  input  logic kick,
  input  logic asleep,
  input  logic tick,
  output logic rst_pulse,
  output logic wake_pulse,
  output logic timed_out
);
  localparam int unsigned CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;

  logic             armed;
  logic             expire;
  logic [CNT_W-1:0] count;

  assign armed = cfg_en | sw_en;

  wdt_counter #(.TIMEOUT(TIMEOUT)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .armed  (armed),
    .kick   (kick),
    .tick   (tick),
    .count  (count),
    .expire (expire)
  );

  wdt_event u_event (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire     (expire),
    .asleep     (asleep),
    .kick       (kick),
    .rst_pulse  (rst_pulse),
    .wake_pulse (wake_pulse),
    .timed_out  (timed_out)
  );

  a_r7_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_en || sw_en) |=> (!rst_pulse && !wake_pulse));

  a_r1_armed_any_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_en || sw_en) && tick && !kick && (count == '0)) |=> (count != '0));

  a_r9_no_pulse_at_reset: assert property (@(posedge clk)
    !rst_n |-> (!rst_pulse && !wake_pulse && !timed_out));

endmodule

// File: tb/test_wdt_sleep_aware.sv
`timescale 1ns/1ps
module test_wdt_sleep_aware;
  localparam int TO = 16;

  logic clk = 1'b0;
  logic rst_n, cfg_en, sw_en, kick, asleep, tick;
  logic rst_pulse, wake_pulse, timed_out;

  int n_checks = 0;
  int n_fail   = 0;
  int seen_rst, seen_wake;

  always #10 clk = ~clk;

  wdt_sleep_aware #(.TIMEOUT(TO)) i_wdt_sleep_aware (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .sw_en(sw_en), .kick(kick),
    .asleep(asleep), .tick(tick), .rst_pulse(rst_pulse),
    .wake_pulse(wake_pulse), .timed_out(timed_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock cycle with the given tick/kick, sampled 1 ns after the edge.
  task automatic cyc(input logic t, input logic k);
    tick = t; kick = k;
    @(posedge clk); #1;
    tick = 0; kick = 0;
    check(!(rst_pulse && wake_pulse), "R10", 1, 0);
    if (rst_pulse)  seen_rst++;
    if (wake_pulse) seen_wake++;
  endtask

  task automatic ticks(input int n);
    seen_rst = 0; seen_wake = 0;
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0);
  endtask

  task automatic t_reset;
    rst_n = 0; cfg_en = 0; sw_en = 0; kick = 0; asleep = 0; tick = 0;
    repeat (3) @(posedge clk);
    #1;
    check(!rst_pulse && !wake_pulse && !timed_out, "R9 in reset",
          {rst_pulse, wake_pulse, timed_out}, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check(!rst_pulse && !wake_pulse && !timed_out, "R9 after release",
          {rst_pulse, wake_pulse, timed_out}, 0);
  endtask

  task automatic t_reset_timeout;
    cfg_en = 1; sw_en = 0; asleep = 0;
    cyc(0, 1);
    ticks(TO - 1);
    check(seen_rst == 0 && seen_wake == 0, "R1/R3 early", seen_rst + seen_wake, 0);
    cyc(1, 0);
    check(rst_pulse == 1, "R3 reset on last tick", rst_pulse, 1);
    check(wake_pulse == 0, "R3 no wake", wake_pulse, 0);
    check(timed_out == 1, "R8 flag set", timed_out, 1);
    cyc(0, 0);
    check(rst_pulse == 0, "R3 single cycle", rst_pulse, 0);
    repeat (5) cyc(0, 0);
    check(timed_out == 1, "R8 flag holds", timed_out, 1);
  endtask

  task automatic t_restart;
    ticks(TO - 1);
    check(seen_rst == 0, "R5 no early pulse", seen_rst, 0);
    cyc(1, 0);
    check(rst_pulse == 1, "R5 second timeout", rst_pulse, 1);
  endtask

  task automatic t_sleep_wake;
    cfg_en = 0; sw_en = 1; asleep = 1;
    cyc(0, 1);
    check(timed_out == 0, "R8 kick clears flag", timed_out, 0);
    seen_rst = 0; seen_wake = 0;
    for (int i = 0; i < TO - 1; i++) begin
      cyc(1, 0);
      cyc(0, 0);
      cyc(0, 0);
    end
    check(seen_wake == 0 && seen_rst == 0, "R2 idle cycles do not count",
          seen_wake + seen_rst, 0);
    cyc(1, 0);
    check(wake_pulse == 1, "R4 wake on timeout", wake_pulse, 1);
    check(rst_pulse == 0, "R4 no reset in sleep", rst_pulse, 0);
    cyc(0, 0);
    check(wake_pulse == 0, "R4 single cycle", wake_pulse, 0);
    asleep = 0;
  endtask

  task automatic t_kick;
    cfg_en = 1; sw_en = 1;
    cyc(0, 1);
    ticks(TO - 1);
    cyc(0, 1);
    ticks(TO - 1);
    check(seen_rst == 0, "R6 kick restarts", seen_rst, 0);
    cyc(1, 1);
    check(rst_pulse == 0 && wake_pulse == 0, "R6 kick beats timeout",
          rst_pulse + wake_pulse, 0);
    ticks(TO - 1);
    check(seen_rst == 0, "R6 full interval after tie", seen_rst, 0);
    cyc(1, 0);
    check(rst_pulse == 1, "R6 timeout after tie", rst_pulse, 1);
  endtask

  task automatic t_disable;
    cfg_en = 1; sw_en = 0;
    cyc(0, 1);
    ticks(5);
    cfg_en = 0; sw_en = 0;
    ticks(3 * TO);
    check(seen_rst == 0 && seen_wake == 0, "R7 silent when off",
          seen_rst + seen_wake, 0);
    sw_en = 1;
    ticks(TO - 1);
    check(seen_rst == 0, "R7 count held at zero", seen_rst, 0);
    cyc(1, 0);
    check(rst_pulse == 1, "R7 full interval after re-arm", rst_pulse, 1);
  endtask

  initial begin
    t_reset;
    t_reset_timeout;
    t_restart;
    t_sleep_wake;
    t_kick;
    t_disable;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule